// File: doc/BRIEF.md
# Dual-Inverter Twelve-Sector PWM Sequencer

This block produces one sampling period of space-vector PWM for a pair of three-level inverters that feed the two ends of an open-end motor winding. A sample strobe loads a sector number (1 to 12) and three cycle counts: the first active time, the second active time and the full period. The block then plays a symmetric pattern: a zero interval, the vector at the sector's lower boundary, the vector at the sector's upper boundary, and a second zero interval. It shows the result as a three-level code for each of the six poles and decodes every code into the four gate signals of that pole's cascaded leg.

The active vectors are combinations of one permutation of the levels {2,1,0} on inverter A and one on inverter B. The zero intervals place the same permutation on both sides, so the sum of pole levels on each inverter, which sets the common-mode voltage, is the same in every interval. A small combinational helper gives the number of samples per sector to use for a given output frequency.

Top module: `dinv_pwm_seq`

## Requirements
- R1: A strobe sampled at clock edge e starts a period in the first cycle after e. The cycle count T0 is Ts−T1−T2. The period runs floor(T0/2) zero cycles, then T1 cycles at the lower location, then T2 cycles at location m, then T0−floor(T0/2) zero cycles. The lower location is m−1, and for m=1 it is location 12.
- R2: When T1+T2 exceeds Ts, no zero cycles are produced and the period lasts T1+T2 cycles.
- R3: Each pole code is 2 bits, with level 0, 1 or 2. Phase a sits in bits [1:0], phase b in [3:2] and phase c in [5:4]. Let P0..P5 be the (a,b,c) triples (2,1,0), (2,0,1), (0,2,1), (0,1,2), (1,0,2), (1,2,0), and let i = L mod 12 for location L. Inverter A shows P[((i+1)/2) mod 6] and inverter B shows P[(i/2+2) mod 6], with integer division.
- R4: In both zero intervals of sector m, both inverters show the inverter-A code of location m.
- R5: Each pole has 4 gate bits at [4p+3:4p]: upper-leg upper, upper-leg lower, lower-leg upper, lower-leg lower. Level 0 gives 0101, level 1 gives 0110 and level 2 gives 1010. Both pairs in a leg are always complementary.
- R6: Outside a period, and from reset, every pole is at level 0.
- R7: done_o is high for exactly one cycle: the cycle just after the last cycle of a period.
- R8: Changes to the sector or time inputs without a strobe have no effect on a period in progress.
- R9: samples_o is 4 for f ≤ 15, 3 for 15 < f ≤ 30, 2 for 30 < f ≤ 45, and 1 above 45.
- R10: On every cycle of a period, each inverter's pole levels sum to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Loads new period parameters and starts a period |
| sector_i | input | 4 | Sector number, 1 to 12 |
| t1_i | input | TW | Lower-location time in cycles |
| t2_i | input | TW | Upper-location time in cycles |
| ts_i | input | TW | Sample period in cycles |
| freq_i | input | FW | Output frequency in Hz |
| pole_a_o | output | 6 | Pole level codes of inverter A |
| pole_b_o | output | 6 | Pole level codes of inverter B |
| gate_a_o | output | 12 | Gate signals of inverter A |
| gate_b_o | output | 12 | Gate signals of inverter B |
| samples_o | output | 3 | Samples per sector for freq_i |
| done_o | output | 1 | One-cycle end-of-period pulse |

## Verification
The sequencer is driven with all twelve sectors using one fixed set of times. This separates the location table entries from each other and checks the wrap from sector 1 to location 12. An odd zero time shows whether the extra zero cycle goes to the trailing interval, and a case with T1+T2 above Ts confirms that no zero cycles are produced. Cases with a zero active time and with T1+T2 exactly equal to Ts expose boundary errors. A run in which the inputs change without a strobe in the middle of a period shows whether the parameters are latched only at the strobe.

// File: rtl/dinv_pkg.sv
package dinv_pkg;

  typedef enum logic [1:0] {
    PH_LEAD  = 2'd0,
    PH_ACT1  = 2'd1,
    PH_ACT2  = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;

  localparam int NLOC  = 12;
  localparam int NPOLE = 3;

  // {c,b,a} packing, 2 bits per pole; all six are permutations of (2,1,0)
  function automatic logic [5:0] perm_code(input int unsigned k);
    logic [5:0] r;
    case (k % 6)
      0: r = {2'd0, 2'd1, 2'd2};
      1: r = {2'd1, 2'd0, 2'd2};
      2: r = {2'd1, 2'd2, 2'd0};
      3: r = {2'd2, 2'd1, 2'd0};
      4: r = {2'd2, 2'd0, 2'd1};
      default: r = {2'd0, 2'd2, 2'd1};
    endcase
    return r;
  endfunction

  function automatic logic [5:0] loc_code_a(input int unsigned idx);
    return perm_code(((idx % NLOC) + 1) / 2);
  endfunction

  function automatic logic [5:0] loc_code_b(input int unsigned idx);
    return perm_code((idx % NLOC) / 2 + 2);
  endfunction

endpackage

// File: rtl/dinv_period_timer.sv
module dinv_period_timer #(
  parameter int TW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [3:0]         sector_i,
  input  logic [TW-1:0]      t1_i,
  input  logic [TW-1:0]      t2_i,
  input  logic [TW-1:0]      ts_i,
  output logic               running_o,
  output dinv_pkg::phase_e   phase_o,
  output logic [3:0]         sector_o,
  output logic               done_o
);
  localparam int CW = TW + 1;

  logic [CW-1:0] sum_w, t0_w, tot_w, b1_w, b2_w, b3_w;
  logic [CW-1:0] b1_q, b2_q, b3_q, tot_q, cnt_q;
  logic [3:0]    sector_q;
  logic          run_q, done_q;

  always_comb begin
    sum_w = {1'b0, t1_i} + {1'b0, t2_i};
    if (sum_w > {1'b0, ts_i}) begin
      t0_w  = '0;
      tot_w = sum_w;
    end else begin
      t0_w  = {1'b0, ts_i} - sum_w;
      tot_w = {1'b0, ts_i};
    end
    b1_w = t0_w >> 1;
    b2_w = b1_w + {1'b0, t1_i};
    b3_w = b2_w + {1'b0, t2_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q     <= '0;
      b2_q     <= '0;
      b3_q     <= '0;
      tot_q    <= '0;
      cnt_q    <= '0;
      sector_q <= 4'd1;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (strobe_i) begin
        b1_q     <= b1_w;
        b2_q     <= b2_w;
        b3_q     <= b3_w;
        tot_q    <= tot_w;
        sector_q <= sector_i;
        cnt_q    <= '0;
        if (tot_w == '0) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          run_q  <= 1'b1;
        end
      end else if (run_q) begin
        if (cnt_q == tot_q - 1'b1) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (cnt_q < b1_q)      phase_o = dinv_pkg::PH_LEAD;
    else if (cnt_q < b2_q) phase_o = dinv_pkg::PH_ACT1;
    else if (cnt_q < b3_q) phase_o = dinv_pkg::PH_ACT2;
    else                   phase_o = dinv_pkg::PH_TRAIL;
  end

  assign running_o = run_q;
  assign sector_o  = sector_q;
  assign done_o    = done_q;

  // R8: latched bounds move only on a strobe
  a_r8_params_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !strobe_i |=> $stable(b3_q) && $stable(sector_q) && $stable(b1_q));

  // R7: done never overlaps an active period
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !run_q);

  // R7: single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !strobe_i |=> !done_q);

endmodule

// File: rtl/dinv_vector_lut.sv
module dinv_vector_lut (
  input  logic             running_i,
  input  dinv_pkg::phase_e phase_i,
  input  logic [3:0]       sector_i,
  output logic [5:0]       pole_a_o,
  output logic [5:0]       pole_b_o
);
  localparam int NLOC = dinv_pkg::NLOC;

  logic [5:0] lut_a [NLOC];
  logic [5:0] lut_b [NLOC];

  for (genvar g = 0; g < NLOC; g++) begin : g_loc
    assign lut_a[g] = dinv_pkg::loc_code_a(g);
    assign lut_b[g] = dinv_pkg::loc_code_b(g);
  end

  logic [3:0] lo_idx, hi_idx;
  logic       in_range;

  always_comb begin
    in_range = (sector_i >= 4'd1) && (sector_i <= 4'd12);
    lo_idx   = in_range ? sector_i - 4'd1 : 4'd0;
    hi_idx   = (in_range && sector_i != 4'd12) ? sector_i : 4'd0;
  end

  always_comb begin
    pole_a_o = '0;
    pole_b_o = '0;
    if (running_i) begin
      unique case (phase_i)
        dinv_pkg::PH_ACT1: begin
          pole_a_o = lut_a[lo_idx];
          pole_b_o = lut_b[lo_idx];
        end
        dinv_pkg::PH_ACT2: begin
          pole_a_o = lut_a[hi_idx];
          pole_b_o = lut_b[hi_idx];
        end
        default: begin
          // zero state: same permutation on both sides keeps common mode
          pole_a_o = lut_a[hi_idx];
          pole_b_o = lut_a[hi_idx];
        end
      endcase
    end
  end

endmodule

// File: rtl/dinv_gate_decode.sv
module dinv_gate_decode #(
  parameter int NPOLE = 3
) (
  input  logic [2*NPOLE-1:0] code_i,
  output logic [4*NPOLE-1:0] gate_o
);
  for (genvar p = 0; p < NPOLE; p++) begin : g_pole
    always_comb begin
      case (code_i[2*p +: 2])
        2'd1:    gate_o[4*p +: 4] = 4'b0110;
        2'd2:    gate_o[4*p +: 4] = 4'b1010;
        default: gate_o[4*p +: 4] = 4'b0101;
      endcase
    end
  end
endmodule

// File: rtl/dinv_rate_select.sv
module dinv_rate_select #(
  parameter int FW     = 8,
  parameter int F_LOW  = 15,
  parameter int F_MID  = 30,
  parameter int F_HIGH = 45
) (
  input  logic [FW-1:0] freq_i,
  output logic [2:0]    samples_o
);
  always_comb begin
    if (32'(freq_i) <= F_LOW)       samples_o = 3'd4;
    else if (32'(freq_i) <= F_MID)  samples_o = 3'd3;
    else if (32'(freq_i) <= F_HIGH) samples_o = 3'd2;
    else                            samples_o = 3'd1;
  end

  // R9: result stays in 1..4
  always_comb begin
    a_r9_range: assert (samples_o >= 3'd1 && samples_o <= 3'd4);
  end
endmodule

// File: rtl/dinv_pwm_seq.sv
module dinv_pwm_seq #(
  parameter int TW = 12,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [3:0]    sector_i,
  input  logic [TW-1:0] t1_i,
  input  logic [TW-1:0] t2_i,
  input  logic [TW-1:0] ts_i,
  input  logic [FW-1:0] freq_i,
  output logic [5:0]    pole_a_o,
  output logic [5:0]    pole_b_o,
  output logic [11:0]   gate_a_o,
  output logic [11:0]   gate_b_o,
  output logic [2:0]    samples_o,
  output logic          done_o
);
  localparam int NPOLE = dinv_pkg::NPOLE;

  logic             running;
  dinv_pkg::phase_e phase;
  logic [3:0]       sector_q;

  dinv_period_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe_i),
    .sector_i  (sector_i),
    .t1_i      (t1_i),
    .t2_i      (t2_i),
    .ts_i      (ts_i),
    .running_o (running),
    .phase_o   (phase),
    .sector_o  (sector_q),
    .done_o    (done_o)
  );

  dinv_vector_lut u_lut (
    .running_i (running),
    .phase_i   (phase),
    .sector_i  (sector_q),
    .pole_a_o  (pole_a_o),
    .pole_b_o  (pole_b_o)
  );

  dinv_gate_decode #(.NPOLE(NPOLE)) u_dec_a (.code_i(pole_a_o), .gate_o(gate_a_o));
  dinv_gate_decode #(.NPOLE(NPOLE)) u_dec_b (.code_i(pole_b_o), .gate_o(gate_b_o));

  dinv_rate_select #(.FW(FW)) u_rate (.freq_i(freq_i), .samples_o(samples_o));

  logic [2:0] lvl_sum_a, lvl_sum_b;
  assign lvl_sum_a = {1'b0, pole_a_o[1:0]} + {1'b0, pole_a_o[3:2]} + {1'b0, pole_a_o[5:4]};
  assign lvl_sum_b = {1'b0, pole_b_o[1:0]} + {1'b0, pole_b_o[3:2]} + {1'b0, pole_b_o[5:4]};

  // R10: constant common mode while a period runs
  a_r10_cm_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> lvl_sum_a == 3'd3 && lvl_sum_b == 3'd3);

  // R4: zero intervals drive identical states
  a_r4_zero_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && (phase == dinv_pkg::PH_LEAD || phase == dinv_pkg::PH_TRAIL)
      |-> pole_a_o == pole_b_o);

  // R6: idle clamps to the zero rail
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> pole_a_o == 6'd0 && pole_b_o == 6'd0);

  // R5: complementary pairs in every leg
  for (genvar p = 0; p < NPOLE; p++) begin : g_chk
    a_r5_leg_compl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_a_o[4*p+3] != gate_a_o[4*p+2] && gate_a_o[4*p+1] != gate_a_o[4*p] &&
      gate_b_o[4*p+3] != gate_b_o[4*p+2] && gate_b_o[4*p+1] != gate_b_o[4*p]);
  end

endmodule

// File: tb/dinv_pwm_seq_test.sv
`timescale 1ns/1ps
module dinv_pwm_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [3:0]  sector = 4'd1;
  logic [11:0] t1 = '0, t2 = '0, ts = '0;
  logic [7:0]  freq = '0;
  logic [5:0]  pole_a, pole_b;
  logic [11:0] gate_a, gate_b;
  logic [2:0]  samples;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dinv_pwm_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .sector_i(sector),
    .t1_i(t1), .t2_i(t2), .ts_i(ts), .freq_i(freq),
    .pole_a_o(pole_a), .pole_b_o(pole_b), .gate_a_o(gate_a), .gate_b_o(gate_b),
    .samples_o(samples), .done_o(done)
  );

  typedef struct {
    logic [5:0] a;
    logic [5:0] b;
    logic       dn;
    int         req;
  } item_t;

  item_t sb_q[$];

  // R3 triples (a,b,c) packed as {c,b,a}
  function automatic logic [5:0] trip(input int k);
    case (k % 6)
      0: return 6'b00_01_10;
      1: return 6'b01_00_10;
      2: return 6'b01_10_00;
      3: return 6'b10_01_00;
      4: return 6'b10_00_01;
      default: return 6'b00_10_01;
    endcase
  endfunction

  function automatic logic [5:0] exp_a(input int loc);
    return trip(((loc % 12) + 1) / 2);
  endfunction

  function automatic logic [5:0] exp_b(input int loc);
    return trip((loc % 12) / 2 + 2);
  endfunction

  // R5 gate patterns
  function automatic logic [11:0] exp_gate(input logic [5:0] c);
    logic [11:0] g;
    for (int p = 0; p < 3; p++) begin
      case (c[2*p +: 2])
        2'd1:    g[4*p +: 4] = 4'b0110;
        2'd2:    g[4*p +: 4] = 4'b1010;
        default: g[4*p +: 4] = 4'b0101;
      endcase
    end
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(pole_a == it.a && pole_b == it.b && done == it.dn,
            $sformatf("R%0d pole/done", it.req),
            {19'd0, done, pole_b, pole_a}, {19'd0, it.dn, it.b, it.a});
      // R5
      check(gate_a == exp_gate(it.a) && gate_b == exp_gate(it.b), "R5 gates",
            {8'd0, gate_b, gate_a}, {8'd0, exp_gate(it.b), exp_gate(it.a)});
    end
  end

  // driver: R1 R2 R4 R6 R7 R8 expectations
  task automatic run_period(input int m, input int a1, input int a2, input int per,
                            input int act_req, input bit disturb);
    int sum, t0, lead, trail, lo;
    sum = a1 + a2;
    t0  = (sum > per) ? 0 : per - sum;
    lead  = t0 / 2;
    trail = t0 - lead;
    lo = (m == 1) ? 12 : m - 1;
    @(negedge clk);
    sector = 4'(m); t1 = 12'(a1); t2 = 12'(a2); ts = 12'(per);
    strobe = 1'b1;
    @(posedge clk);
    for (int j = 0; j < lead; j++)  sb_q.push_back('{exp_a(m), exp_a(m), 1'b0, 4});
    for (int j = 0; j < a1; j++)    sb_q.push_back('{exp_a(lo), exp_b(lo), 1'b0, act_req});
    for (int j = 0; j < a2; j++)    sb_q.push_back('{exp_a(m), exp_b(m), 1'b0, act_req});
    for (int j = 0; j < trail; j++) sb_q.push_back('{exp_a(m), exp_a(m), 1'b0, 4});
    sb_q.push_back('{6'd0, 6'd0, 1'b1, 7});   // R7 done, R6 idle
    #1 strobe = 1'b0;
    if (disturb) begin
      // R8: inputs move without a strobe
      repeat (2) @(posedge clk);
      #1;
      sector = 4'd5; t1 = 12'd1; t2 = 12'd1; ts = 12'd2;
    end
    while (sb_q.size() != 0) @(posedge clk);
    @(negedge clk);
    // R7 pulse ended, R6 still idle
    check(done == 1'b0 && pole_a == 6'd0, "R7 done low after pulse",
          {25'd0, done, pole_a}, 32'd0);
  endtask

  task automatic check_rate(input int f, input int expn);
    freq = 8'(f);
    #1;
    check(samples == 3'(expn), $sformatf("R9 f=%0d", f), 32'(samples), 32'(expn));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    check(pole_a == 6'd0 && pole_b == 6'd0 && done == 1'b0, "R6 reset poles",
          {19'd0, done, pole_b, pole_a}, 32'd0);
    check(gate_a == 12'h555 && gate_b == 12'h555, "R5 reset gates",
          {8'd0, gate_b, gate_a}, {8'd0, 12'h555, 12'h555});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 odd zero time, extra cycle trails
    run_period(1, 3, 4, 12, 1, 1'b0);
    // R3 all twelve sectors
    for (int m = 1; m <= 12; m++) run_period(m, 2, 3, 9, 3, 1'b0);
    // R2 twelve-step
    run_period(7, 5, 6, 8, 2, 1'b0);
    // R1 zero T1, sum equals Ts, sector 12
    run_period(12, 0, 5, 5, 1, 1'b0);
    // R8 mid-period disturbance
    run_period(4, 4, 1, 10, 8, 1'b1);
    // R1 larger period
    run_period(9, 6, 2, 11, 1, 1'b0);

    // R9 rate bands
    check_rate(0, 4);  check_rate(15, 4); check_rate(16, 3); check_rate(30, 3);
    check_rate(31, 2); check_rate(45, 2); check_rate(46, 1); check_rate(50, 1);
    check_rate(60, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule